// File: doc/BRIEF.md
# Bank-Remapping Address Decoder

This block sits between a 16-bit processor core and its memories and peripherals, on a 20-bit byte address bus. Each access carries a logical address. The top eight bits pick one of 256 banks of 4 KB. A bank table turns that bank into an area number, and the area number gives a physical 4 KB page. The physical address is then decoded into RAM, ROM, one of sixteen 256-byte device slots, or the processor's own register window. The decoder drives one select per target and the physical address that goes with it. The top 128 bytes of the logical space, 0xFFF80 to 0xFFFFF, go straight to the register window and never pass through the table.

The block also holds device slot 15, the mainboard slot. Software reads the mainboard's identity and feature bytes there. It programs the bank table through two registers in that slot. The first register chooses which bank to configure. Writing the second register sets that bank's area, and reading it returns the area the bank has now. Any read that no target can answer is served by the block itself with 0xFF. This covers reserved regions, reserved areas and device slots with nothing attached. An empty slot therefore reports the no-device vendor ID 0xFFFF.

All routing is combinational within the access cycle. Only the bank-select register and the bank table are state.

Top module: `addr_bank_mmu`

## Requirements
- R1: After reset, the bank table gives the physical map for every logical address. Banks 0x00–0xEF select RAM at the same address. Banks 0xF0–0xFB select RAM at the address minus 0xF0000. Bank 0xFC reads 0xFF and selects nothing. Bank 0xFD is the device space. Banks 0xFE–0xFF select ROM, except for the register window. The bank-select register resets to 0.
- R2: A bank mapped to an area A in the range 0–239 asserts `ram_sel`, with `mem_addr` = A·4096 + (address bits 11:0).
- R3: Area 240 selects ROM at 0xFE000 plus the offset. Area 241 selects ROM at 0xFF000 plus the offset. An offset of 0xF80 or more in area 241 reaches physical 0xFFF80 and above, which selects the register window instead.
- R4: Area 242 selects the device space at 0xFD000 plus the offset. Offset bits 11:8 give the slot number. Slots 0–14 raise the matching `dev_sel` bit only when that slot's `dev_present` bit is 1. Slot 15 is the mainboard slot and is served by the block.
- R5: Areas 243–255 select no target. A read there returns 0xFF with `rd_local` high.
- R6: A logical address of 0xFFF80 or more asserts `creg_sel` with `mem_addr` equal to the logical address, whatever the table holds for bank 0xFF.
- R7: Mainboard offsets 0–1 return the vendor ID, low byte first. Offset 2 returns the device ID and offset 3 the device class. Offsets 4–7 return a 32-bit feature word, low byte first. In that word, bit 0 is 1 (MMU present), bit 1 equals the DMA-present parameter, and all other bits are 0.
- R8: Writing mainboard offset 8 sets the bank-select register, and reading offset 8 returns it. Writing offset 9 loads the selected bank's table entry, and reading offset 9 returns that entry. A table write changes routing from the next cycle onward.
- R9: A read of an empty device slot returns 0xFF and raises no `dev_sel` bit. Mainboard offsets 10–255 read 0xFF, and writes to them change no state.
- R10: When `req_valid` is high, exactly one of the following is asserted: `ram_sel`, `rom_sel`, `creg_sel`, a `dev_sel` bit, or `rd_local` (the last for reads only). When `req_valid` is low, none of them is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 20 | Logical byte address |
| req_wdata | input | 8 | Write data byte |
| dev_present | input | 15 | Bit i is 1 when a device is attached in slot i |
| mem_addr | output | 20 | Physical address for the selected target |
| ram_sel | output | 1 | RAM selected |
| rom_sel | output | 1 | ROM selected |
| creg_sel | output | 1 | Processor register window selected |
| dev_sel | output | 15 | One-hot select of external device slot |
| rd_local | output | 1 | Read data is supplied by this block |
| rd_data | output | 8 | Local read data (valid when rd_local is high) |

## Verification
Two cases are hard to reach from the ports. The first is a bank reaching area 241 at an offset of 0xF80 or more. That lands in the register window by a physical route rather than through the logical exemption. The second is bank 0xFF being remapped while the window must stay fixed. Neither case can happen until the bank table has been rewritten through the mainboard slot. So the bench first reads back all 256 reset entries through the select/data register pair. It then moves one scratch bank through every area value, from 0 to 255, probing four offsets each time. This includes 0xF80 and 0xFFF. Finally it remaps bank 0xFF to a RAM area and to a reserved area, and confirms the top 128 bytes stay on the register window.

// File: rtl/amm_pkg.sv
package amm_pkg;

    localparam int ADDR_W    = 20;
    localparam int OFF_W     = 12;
    localparam int BANK_W    = ADDR_W - OFF_W;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int AREA_W    = 8;
    localparam int DATA_W    = 8;
    localparam int SLOT_W    = 4;
    localparam int EXT_SLOTS = (1 << SLOT_W) - 1;
    localparam int REG_OFF_W = 8;

    localparam logic [AREA_W-1:0] RAM_AREA_LAST = 8'd239;
    localparam logic [AREA_W-1:0] ROM_AREA_LO   = 8'd240;
    localparam logic [AREA_W-1:0] ROM_AREA_HI   = 8'd241;
    localparam logic [AREA_W-1:0] IO_AREA       = 8'd242;
    localparam logic [AREA_W-1:0] VOID_AREA     = 8'd243;

    localparam logic [ADDR_W-1:0] MIRROR_BASE = 20'hF0000;
    localparam logic [ADDR_W-1:0] RSV_BASE    = 20'hFC000;
    localparam logic [ADDR_W-1:0] IO_BASE     = 20'hFD000;
    localparam logic [ADDR_W-1:0] ROM_BASE    = 20'hFE000;
    localparam logic [ADDR_W-1:0] CREG_BASE   = 20'hFFF80;

    localparam logic [SLOT_W-1:0]    BOARD_SLOT = 4'hF;
    localparam logic [REG_OFF_W-1:0] OFF_BSEL   = 8'h08;
    localparam logic [REG_OFF_W-1:0] OFF_BMAP   = 8'h09;
    localparam logic [DATA_W-1:0]    FILL_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_ROM,
        TGT_IO,
        TGT_CREG
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] addr;
    } route_t;

    // Table contents after reset: the physical map seen through the banks.
    function automatic logic [AREA_W-1:0] reset_area(input logic [BANK_W-1:0] bank);
        logic [AREA_W-1:0] a;
        if (bank <= RAM_AREA_LAST)                 a = bank;
        else if (bank < RSV_BASE[ADDR_W-1:OFF_W])  a = bank - ROM_AREA_LO;
        else if (bank == RSV_BASE[ADDR_W-1:OFF_W]) a = VOID_AREA;
        else if (bank == IO_BASE[ADDR_W-1:OFF_W])  a = IO_AREA;
        else if (bank == ROM_BASE[ADDR_W-1:OFF_W]) a = ROM_AREA_LO;
        else                                       a = ROM_AREA_HI;
        return a;
    endfunction

    // Area number plus page offset to a physical address; TGT_NONE for reserved areas.
    function automatic route_t area_to_phys(input logic [AREA_W-1:0] area,
                                            input logic [OFF_W-1:0]  off);
        route_t r;
        r.tgt  = TGT_RAM;
        r.addr = {area, off};
        if (area == ROM_AREA_LO)
            r.addr = {ROM_BASE[ADDR_W-1:OFF_W], off};
        else if (area == ROM_AREA_HI)
            r.addr = {ROM_BASE[ADDR_W-1:OFF_W] + 8'd1, off};
        else if (area == IO_AREA)
            r.addr = {IO_BASE[ADDR_W-1:OFF_W], off};
        else if (area > IO_AREA) begin
            r.tgt  = TGT_NONE;
            r.addr = '0;
        end
        return r;
    endfunction

    // Physical region decode, folding the RAM mirror.
    function automatic route_t phys_decode(input logic [ADDR_W-1:0] p);
        route_t r;
        r.addr = p;
        if (p < MIRROR_BASE)    r.tgt = TGT_RAM;
        else if (p < RSV_BASE) begin
            r.tgt  = TGT_RAM;
            r.addr = p - MIRROR_BASE;
        end
        else if (p < IO_BASE)   r.tgt = TGT_NONE;
        else if (p < ROM_BASE)  r.tgt = TGT_IO;
        else if (p < CREG_BASE) r.tgt = TGT_ROM;
        else                    r.tgt = TGT_CREG;
        return r;
    endfunction

endpackage

// File: rtl/amm_bank_table.sv
module amm_bank_table
    import amm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lk_bank,
    output logic [AREA_W-1:0] lk_area,
    input  logic [BANK_W-1:0] cfg_bank,
    output logic [AREA_W-1:0] cfg_area,
    input  logic              wr_en,
    input  logic [AREA_W-1:0] wr_area
);

    logic [AREA_W-1:0] tbl [NUM_BANKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BANKS; i++)
                tbl[i] <= reset_area(BANK_W'(i));
        end else if (wr_en) begin
            tbl[cfg_bank] <= wr_area;
        end
    end

    assign lk_area  = tbl[lk_bank];
    assign cfg_area = tbl[cfg_bank];

    // R8
    tbl_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tbl[$past(cfg_bank)] == $past(wr_area));

endmodule

// File: rtl/amm_board_slot.sv
module amm_board_slot
    import amm_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h8001,
    parameter logic [7:0]  DEVICE_ID    = 8'h01,
    parameter logic [7:0]  DEVICE_CLASS = 8'h80,
    parameter bit          HAS_DMA      = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit,
    input  logic                 wr,
    input  logic [REG_OFF_W-1:0] off,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [BANK_W-1:0]    sel_bank,
    input  logic [AREA_W-1:0]    sel_area,
    output logic                 map_we
);

    localparam logic [31:0] FEATURES = {30'd0, HAS_DMA, 1'b1};

    logic [BANK_W-1:0] bsel_q;

    always_ff @(posedge clk) begin
        if (rst)
            bsel_q <= '0;
        else if (hit && wr && off == OFF_BSEL)
            bsel_q <= wdata;
    end

    assign sel_bank = bsel_q;
    assign map_we   = hit && wr && off == OFF_BMAP;

    always_comb begin
        unique case (off)
            8'h00:    rdata = VENDOR_ID[7:0];
            8'h01:    rdata = VENDOR_ID[15:8];
            8'h02:    rdata = DEVICE_ID;
            8'h03:    rdata = DEVICE_CLASS;
            8'h04:    rdata = FEATURES[7:0];
            8'h05:    rdata = FEATURES[15:8];
            8'h06:    rdata = FEATURES[23:16];
            8'h07:    rdata = FEATURES[31:24];
            OFF_BSEL: rdata = bsel_q;
            OFF_BMAP: rdata = sel_area;
            default:  rdata = FILL_BYTE;
        endcase
    end

    // R8
    bsel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wr && off == OFF_BSEL) |=> sel_bank == $past(wdata));

    // R9
    bsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && wr && off == OFF_BSEL) |=> $stable(sel_bank));

endmodule

// File: rtl/amm_route.sv
module amm_route
    import amm_pkg::*;
(
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    laddr,
    input  logic [AREA_W-1:0]    area,
    input  logic [EXT_SLOTS-1:0] dev_present,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 ram_sel,
    output logic                 rom_sel,
    output logic                 creg_sel,
    output logic [EXT_SLOTS-1:0] dev_sel,
    output logic                 board_hit,
    output logic                 void_hit
);

    route_t            via_area;
    route_t            phys;
    logic [SLOT_W-1:0] slot;
    logic              io_hit;

    always_comb begin
        via_area = area_to_phys(area, laddr[OFF_W-1:0]);
        if (laddr >= CREG_BASE) begin
            phys.tgt  = TGT_CREG;
            phys.addr = laddr;
        end else if (via_area.tgt == TGT_NONE) begin
            phys = via_area;
        end else begin
            phys = phys_decode(via_area.addr);
        end
    end

    assign slot     = phys.addr[OFF_W-1:REG_OFF_W];
    assign io_hit   = req_valid && phys.tgt == TGT_IO;
    assign mem_addr = phys.addr;
    assign ram_sel  = req_valid && phys.tgt == TGT_RAM;
    assign rom_sel  = req_valid && phys.tgt == TGT_ROM;
    assign creg_sel = req_valid && phys.tgt == TGT_CREG;

    for (genvar g = 0; g < EXT_SLOTS; g++) begin : g_slot
        assign dev_sel[g] = io_hit && slot == SLOT_W'(g) && dev_present[g];
    end

    assign board_hit = io_hit && slot == BOARD_SLOT;
    assign void_hit  = (req_valid && phys.tgt == TGT_NONE) ||
                       (io_hit && slot != BOARD_SLOT && !dev_present[slot[SLOT_W-1:0] == BOARD_SLOT ? 0 : slot]);

endmodule

// File: rtl/addr_bank_mmu.sv
module addr_bank_mmu
    import amm_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h8001,
    parameter logic [7:0]  DEVICE_ID    = 8'h01,
    parameter logic [7:0]  DEVICE_CLASS = 8'h80,
    parameter bit          HAS_DMA      = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [EXT_SLOTS-1:0] dev_present,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 ram_sel,
    output logic                 rom_sel,
    output logic                 creg_sel,
    output logic [EXT_SLOTS-1:0] dev_sel,
    output logic                 rd_local,
    output logic [DATA_W-1:0]    rd_data
);

    logic [AREA_W-1:0] lk_area;
    logic [AREA_W-1:0] cfg_area;
    logic [BANK_W-1:0] cfg_bank;
    logic              map_we;
    logic              board_hit;
    logic              void_hit;
    logic [DATA_W-1:0] board_rdata;

    amm_bank_table u_table (
        .clk      (clk),
        .rst      (rst),
        .lk_bank  (req_addr[ADDR_W-1:OFF_W]),
        .lk_area  (lk_area),
        .cfg_bank (cfg_bank),
        .cfg_area (cfg_area),
        .wr_en    (map_we),
        .wr_area  (req_wdata)
    );

    amm_route u_route (
        .req_valid   (req_valid),
        .laddr       (req_addr),
        .area        (lk_area),
        .dev_present (dev_present),
        .mem_addr    (mem_addr),
        .ram_sel     (ram_sel),
        .rom_sel     (rom_sel),
        .creg_sel    (creg_sel),
        .dev_sel     (dev_sel),
        .board_hit   (board_hit),
        .void_hit    (void_hit)
    );

    amm_board_slot #(
        .VENDOR_ID    (VENDOR_ID),
        .DEVICE_ID    (DEVICE_ID),
        .DEVICE_CLASS (DEVICE_CLASS),
        .HAS_DMA      (HAS_DMA)
    ) u_board (
        .clk      (clk),
        .rst      (rst),
        .hit      (board_hit),
        .wr       (req_write),
        .off      (mem_addr[REG_OFF_W-1:0]),
        .wdata    (req_wdata),
        .rdata    (board_rdata),
        .sel_bank (cfg_bank),
        .sel_area (cfg_area),
        .map_we   (map_we)
    );

    assign rd_local = !req_write && (board_hit || void_hit);
    assign rd_data  = !rd_local ? '0 : (board_hit ? board_rdata : FILL_BYTE);

    // R6
    win_exempt_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr >= CREG_BASE) |-> (creg_sel && mem_addr == req_addr));

    // R10
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_sel, rom_sel, creg_sel, dev_sel, rd_local}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(ram_sel || rom_sel || creg_sel || (|dev_sel) || rd_local));

    // R5
    void_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_local && void_hit) |-> rd_data == FILL_BYTE);

    // R2
    page_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_sel || rom_sel || (|dev_sel)) |-> mem_addr[OFF_W-1:0] == req_addr[OFF_W-1:0]);

endmodule

// File: tb/addr_bank_mmu_tb.sv
`timescale 1ns/1ps
module addr_bank_mmu_tb;

    localparam logic [15:0] T_VENDOR = 16'h8123;
    localparam logic [7:0]  T_DEVID  = 8'h42;
    localparam logic [7:0]  T_CLASS  = 8'h90;
    localparam logic [14:0] T_PRES   = 15'h4C35;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [14:0] dev_present = T_PRES;
    logic [19:0] mem_addr;
    logic        ram_sel, rom_sel, creg_sel, rd_local;
    logic [14:0] dev_sel;
    logic [7:0]  rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int exp_area [256];

    always #2 clk = ~clk;

    addr_bank_mmu #(
        .VENDOR_ID    (T_VENDOR),
        .DEVICE_ID    (T_DEVID),
        .DEVICE_CLASS (T_CLASS),
        .HAS_DMA      (1'b1)
    ) u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .dev_present (dev_present),
        .mem_addr (mem_addr), .ram_sel (ram_sel), .rom_sel (rom_sel),
        .creg_sel (creg_sel), .dev_sel (dev_sel), .rd_local (rd_local), .rd_data (rd_data)
    );

    function automatic int rst_area(int b);
        if (b < 240)  return b;
        if (b < 252)  return b - 240;
        if (b == 252) return 243;
        if (b == 253) return 242;
        if (b == 254) return 240;
        return 241;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(int a);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a[19:0];
        #1;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a[19:0];
        req_wdata = d[7:0];
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic set_map(int b, int area);
        wr(32'hFDF08, b);
        wr(32'hFDF09, area);
        exp_area[b] = area;
    endtask

    // kinds: 1 ram, 2 rom, 3 creg, 4 device, 5 local(board), 6 local(fill)
    task automatic check_route(int a, string req);
        int area, off, kind, ea, slot, ak, nsel;
        off  = a & 32'hFFF;
        area = exp_area[a >> 12];
        ea   = 0;
        slot = 0;
        if (a >= 32'hFFF80) begin kind = 3; ea = a; end
        else if (area < 240) begin kind = 1; ea = area * 4096 + off; end
        else if (area == 240 || area == 241) begin
            ea   = 32'hFE000 + (area - 240) * 4096 + off;
            kind = (ea >= 32'hFFF80) ? 3 : 2;
        end else if (area == 242) begin
            slot = off >> 8;
            ea   = 32'hFD000 + off;
            if (slot == 15) kind = 5;
            else if (T_PRES[slot]) kind = 4;
            else kind = 6;
        end else kind = 6;
        probe(a);
        nsel = int'(ram_sel) + int'(rom_sel) + int'(creg_sel) + $countones(dev_sel) + int'(rd_local);
        chk(nsel == 1, "R10 one target", nsel, 1);
        ak = ram_sel ? 1 : rom_sel ? 2 : creg_sel ? 3 : (|dev_sel) ? 4 :
             (rd_local ? ((kind == 5) ? 5 : 6) : 0);
        chk(ak == kind, req, ak, kind);
        if (kind <= 4) chk(mem_addr == ea[19:0], req, int'(mem_addr), ea);
        if (kind == 4) chk(dev_sel == 15'(1 << slot), "R4 slot select", int'(dev_sel), 1 << slot);
        if (kind == 6) chk(rd_data == 8'hFF, "R5/R9 fill byte", int'(rd_data), 32'hFF);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int offs [4];
        offs = '{0, 32'hABC, 32'hF80, 32'hFFF};
        for (int b = 0; b < 256; b++) exp_area[b] = rst_area(b);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 idle
        #1;
        chk(!(ram_sel || rom_sel || creg_sel || (|dev_sel) || rd_local), "R10 idle", 0, 0);

        // R1 bank-select reset value
        probe(32'hFDF08);
        chk(rd_data == 8'h00, "R1 select reset", int'(rd_data), 0);

        // R1 reset table readback, every bank
        for (int b = 0; b < 256; b++) begin
            wr(32'hFDF08, b);
            probe(32'hFDF09);
            chk(rd_data == 8'(rst_area(b)), "R1 reset entry", int'(rd_data), rst_area(b));
        end

        // R1 reset decode, every bank at three offsets
        for (int b = 0; b < 256; b++) begin
            check_route(b * 4096, "R1 reset map");
            check_route(b * 4096 + 32'h7FF, "R1 reset map");
            check_route(b * 4096 + 32'hFFF, "R1 reset map");
        end

        // R4 R9 device slots
        for (int s = 0; s < 16; s++) begin
            check_route(32'hFD000 + s * 256, "R4 slot route");
            check_route(32'hFD003 + s * 256, "R9 slot route");
        end

        // R7 identity bytes
        probe(32'hFDF00); chk(rd_data == T_VENDOR[7:0],  "R7 vendor lo", int'(rd_data), T_VENDOR[7:0]);
        probe(32'hFDF01); chk(rd_data == T_VENDOR[15:8], "R7 vendor hi", int'(rd_data), T_VENDOR[15:8]);
        probe(32'hFDF02); chk(rd_data == T_DEVID,        "R7 device id", int'(rd_data), T_DEVID);
        probe(32'hFDF03); chk(rd_data == T_CLASS,        "R7 class", int'(rd_data), T_CLASS);
        probe(32'hFDF04); chk(rd_data == 8'h03,          "R7 features b0", int'(rd_data), 3);
        for (int k = 5; k < 8; k++) begin
            probe(32'hFDF00 + k);
            chk(rd_data == 8'h00, "R7 features upper", int'(rd_data), 0);
        end

        // R9 other board offsets
        wr(32'hFDF08, 32'h37);
        foreach (offs[i]) begin
            probe(32'hFDF0A + (offs[i] & 32'hF5));
            chk(rd_data == 8'hFF, "R9 unused offset", int'(rd_data), 32'hFF);
        end
        wr(32'hFDF20, 32'h00);
        wr(32'hFDF0A, 32'h12);
        probe(32'hFDF08);
        chk(rd_data == 8'h37, "R9 write ignored select", int'(rd_data), 32'h37);
        probe(32'hFDF09);
        chk(rd_data == 8'h37, "R9 write ignored table", int'(rd_data), 32'h37);
        probe(32'hFDF20);
        chk(rd_data == 8'hFF, "R9 write ignored read", int'(rd_data), 32'hFF);

        // R2 R3 R4 R5 R8 full area sweep on scratch bank 0x12
        for (int a = 0; a < 256; a++) begin
            string tag;
            tag = (a < 240) ? "R2 ram area" : (a < 242) ? "R3 rom area" :
                  (a == 242) ? "R4 io area" : "R5 reserved area";
            set_map(32'h12, a);
            probe(32'hFDF09);
            chk(rd_data == 8'(a), "R8 readback", int'(rd_data), a);
            foreach (offs[i]) check_route(32'h12000 + offs[i], tag);
        end
        set_map(32'h12, 32'h12);

        // R6 window exempt with bank 0xFF remapped
        set_map(32'hFF, 5);
        check_route(32'hFFF80, "R6 window");
        check_route(32'hFFFFF, "R6 window");
        check_route(32'hFF000, "R6 bank FF below window");
        set_map(32'hFF, 250);
        check_route(32'hFFFC0, "R6 window reserved area");
        check_route(32'hFFF7F, "R6 bank FF below window");
        set_map(32'hFF, 241);
        check_route(32'hFFF80, "R6 window restored");

        // R10 idle after traffic
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 20'hFDF00;
        #1;
        chk(!(ram_sel || rom_sel || creg_sel || (|dev_sel) || rd_local), "R10 idle", 1, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule